// File: doc/BRIEF.md
# Serial Control Register Port

This block is a chip-select framed serial slave that gives a host access to a small bank of 8-bit control registers. The host drives a serial clock, a data line into the block and an active-low select; the block answers on a serial data line with a separate output enable, so that a pad or an external tristate buffer can release the line when the block is not talking. All three serial inputs are brought into the block's system clock domain through synchronizers, and every internal decision is taken on detected serial clock edges.

An exchange is built from bytes of eight serial clock pulses, most significant bit first. The first byte is a command: it either names a register to be written or read, in which case a second byte follows, or it is the single-byte power command, which only sets the power-down flag. The second byte may follow the first in the same select window or come in a later window of its own. A write takes effect when the second byte is complete; on a read the addressed register is shifted out during the second byte. A select rise in the middle of a byte throws that byte away and cancels any pending second byte.

Top module: `ctrl_port`

## Requirements
- R1: After reset every register reads 0x00, `pwr_down` is 1 and `sdo_en` is 0.
- R2: A command byte with bit 7 = 0 and a register address in bits 6..3 (bits 2..0 = 0), followed in the same select window by a data byte, writes that data byte into the addressed register once the eighth bit of the data byte has been clocked in; data is sampled on serial clock rising edges, MSB first.
- R3: The data byte of a two-byte command may arrive in a separate select window; the pending command survives a select rise that falls exactly between bytes.
- R4: A command byte whose bits 7..3 are 01111 is the power command: it is complete after one byte, sets `pwr_down` to its bit 0, and the next byte is decoded as a new command byte.
- R5: A command byte with bit 7 = 1 reads the register in bits 6..3: during the following byte `sdo_en` is 1 and `sdo` carries the register MSB first, changing after serial clock falling edges, stable before each rising edge; the data clocked in during that byte changes no register.
- R6: `sdo_en` is 0 during command bytes, during the data byte of a write, and while the select is high.
- R7: A select rise after 1 to 7 bits of a byte discards those bits and cancels a pending second byte; the next complete byte is decoded as a command byte.
- R8: A write command whose address is 10 to 14 changes no register and no power state.
- R9: Serial clock pulses while the select is high have no effect on the registers or on the command state.
- R10: A select rise that coincides with the eighth rising serial clock edge of a byte counts that byte as complete, so it lies on a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| cs_n | input | 1 | Active-low select framing the transfers |
| sdo | output | 1 | Serial read data, MSB first |
| sdo_en | output | 1 | High while `sdo` should be driven onto the line |
| pwr_down | output | 1 | Power-down flag set by the power command |
| regs_flat | output | NREG*8 | All control registers, register i in bits i*8+7..i*8 |

## Verification
The two events that can share a synchronized cycle are the completion of a byte on the eighth rising serial clock edge and a select rise that would abort a partial byte. The bench provokes this by raising the serial clock and the select in the same instant on the last bit of a command byte, so both pass the equal-length synchronizers together, and then sends the data byte in a fresh window. The case is judged at the register outputs: the data byte must land in the addressed register, which only happens if the coincident edge was counted and the pending command kept.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam logic [4:0] PWR_TAG = 5'b01111;

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/ctrl_port_sync.sv
module ctrl_port_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctrl_port_rx.sv
module ctrl_port_rx
  import ctrl_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              abort,
  output logic              fall_act,
  output logic              cs_low
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic              csn_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  nxt_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rise;
  logic              cs_rise;

  // edges only count while the select was already low in the previous sample
  assign rise     = sclk_s & ~sclk_q & ~csn_q;
  assign fall_act = ~sclk_s & sclk_q & ~csn_q & (bit_cnt != '0);
  assign cs_rise  = csn_s & ~csn_q;
  assign cs_low   = ~csn_q;

  always_comb begin
    nxt_cnt = bit_cnt;
    if (rise) nxt_cnt = (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
  end

  assign byte_vld  = rise && (bit_cnt == LAST);
  assign byte_data = {shreg[BYTE_W-2:0], sdi_s};
  assign abort     = cs_rise && (nxt_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
      if (csn_s) bit_cnt <= '0;
      else       bit_cnt <= nxt_cnt;
      if (rise) shreg <= byte_data;
    end
  end
endmodule

// File: rtl/ctrl_port_ctl.sv
module ctrl_port_ctl
  import ctrl_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              abort,
  input  logic              fall_act,
  input  logic              cs_low,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              pwr_down,
  output logic              sdo,
  output logic              sdo_en
);
  phase_t            phase;
  cmd_t              cmd;
  logic [BYTE_W-1:0] out_sr;
  logic              is_pwr;
  logic              talk;

  assign is_pwr  = (byte_data[7:3] == PWR_TAG);
  assign rd_addr = byte_data[ADDR_W+2:3];
  assign wr_en   = byte_vld && (phase == PH_DATA) && !cmd.rd;
  assign wr_addr = cmd.addr;
  assign wr_data = byte_data;
  assign talk    = cs_low && (phase == PH_DATA) && cmd.rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      cmd      <= '0;
      out_sr   <= '0;
      pwr_down <= 1'b1;
      sdo      <= 1'b0;
      sdo_en   <= 1'b0;
    end else begin
      if (abort) begin
        phase <= PH_CMD;
      end else if (byte_vld) begin
        if (phase == PH_CMD) begin
          if (is_pwr) begin
            pwr_down <= byte_data[0];
          end else begin
            phase    <= PH_DATA;
            cmd.rd   <= byte_data[7];
            cmd.addr <= rd_addr;
            out_sr   <= rd_data;
          end
        end else begin
          phase <= PH_CMD;
        end
      end else if (fall_act && phase == PH_DATA) begin
        out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end
      sdo_en <= talk;
      sdo    <= talk & out_sr[BYTE_W-1];
    end
  end
endmodule

// File: rtl/ctrl_port_bank.sv
module ctrl_port_bank
  import ctrl_port_pkg::*;
#(
  parameter int NREG = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                      regs[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))      regs[i] <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/ctrl_port.sv
module ctrl_port
  import ctrl_port_pkg::*;
#(
  parameter int NREG        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic                   cs_n,
  output logic                   sdo,
  output logic                   sdo_en,
  output logic                   pwr_down,
  output logic [NREG*BYTE_W-1:0] regs_flat
);
  logic              sclk_s, sdi_s, csn_s;
  logic              byte_vld, abort, fall_act, cs_low;
  logic [BYTE_W-1:0] byte_data, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;

  ctrl_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q({csn_s, sclk_s, sdi_s})
  );

  ctrl_port_rx rx_i (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdi_s(sdi_s), .csn_s(csn_s),
    .byte_vld(byte_vld), .byte_data(byte_data), .abort(abort),
    .fall_act(fall_act), .cs_low(cs_low)
  );

  ctrl_port_ctl ctl_i (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .abort(abort), .fall_act(fall_act), .cs_low(cs_low), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwr_down(pwr_down), .sdo(sdo), .sdo_en(sdo_en)
  );

  ctrl_port_bank #(.NREG(NREG)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
  );
endmodule

// File: rtl/ctrl_port_chk.sv
module ctrl_port_chk #(
  parameter int NREG = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              sdi,
  input logic              cs_n,
  input logic              sdo,
  input logic              sdo_en,
  input logic              pwr_down,
  input logic [NREG*8-1:0] regs_flat
);
  logic              seen = 1'b0;
  logic              past_ok;
  logic [NREG*8-1:0] regs_d;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk) begin
    seen    <= 1'b1;
    regs_d  <= regs_flat;
    past_ok <= !rst;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_chg
    assign chg[i] = regs_flat[i*8 +: 8] != regs_d[i*8 +: 8];
  end

  // R1: one cycle after reset the outputs are in their reset state
  p_reset_state_r1: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (regs_flat == '0 && pwr_down && !sdo_en));

  // R2: a completed write touches a single register at a time
  p_one_reg_per_write_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $onehot0(chg));

  // R4: the power flag and the registers never change together
  p_pwr_apart_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(pwr_down) |-> (chg == '0));

  // R6: with the select held high long enough, the output is released
  p_quiet_when_deselected_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !sdo_en);

  // R9: with the select held high, registers and power flag hold
  p_hold_when_deselected_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4) && $past(cs_n, 5))
      |-> (chg == '0 && $stable(pwr_down)));

  // R5: read data is only presented while enabled
  p_sdo_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !sdo_en |-> !sdo);
endmodule

bind ctrl_port ctrl_port_chk #(.NREG(NREG)) chk_i (.*);

// File: tb/ctrl_port_tb_top.sv
module ctrl_port_tb_top;
  localparam int NREG = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic sdo, sdo_en, pwr_down;
  logic [NREG*8-1:0] regs_flat;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NREG];
  logic       mdl_pd;

  always #5 clk = ~clk;

  ctrl_port #(.NREG(NREG)) dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .sdo(sdo), .sdo_en(sdo_en), .pwr_down(pwr_down), .regs_flat(regs_flat)
  );

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    logic [NREG*8-1:0] exp;
    for (int i = 0; i < NREG; i++) exp[i*8 +: 8] = mdl[i];
    chk(regs_flat == exp, req, 128'(regs_flat), 128'(exp));
    chk(pwr_down == mdl_pd, req, 128'(pwr_down), 128'(mdl_pd));
  endtask

  task automatic cs_on;  cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic cs_off; cs_n = 1'b1; wait_clk(HALF); endtask

  task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx,
                           output logic en_all, output logic en_any);
    en_all = 1'b1; en_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i]  = sdo;
      en_all = en_all & sdo_en;
      en_any = en_any | sdo_en;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rx; logic ea, en;
    cs_on;
    send_byte({1'b0, a, 3'b000}, rx, ea, en);
    chk(!en, "R6 write cmd byte", 128'(en), 0);
    send_byte(d, rx, ea, en);
    chk(!en, "R6 write data byte", 128'(en), 0);
    cs_off;
    if (a < NREG) mdl[a] = d;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl_pd = 1'b1;
    check_regs("R1 reset");
    chk(sdo_en == 1'b0, "R1 sdo_en", 128'(sdo_en), 0);
  endtask

  task automatic t_write_contig;
    wr(4'd2, 8'h5C);
    check_regs("R2 contiguous write");
    wr(4'd9, 8'hA1);
    wr(4'd0, 8'hFF);
    check_regs("R2 writes at both ends");
  endtask

  task automatic t_write_split;
    logic [7:0] rx; logic ea, en;
    cs_on; send_byte({1'b0, 4'd4, 3'b000}, rx, ea, en); cs_off;
    check_regs("R3 pending after first window");
    cs_on; send_byte(8'h3E, rx, ea, en); cs_off;
    mdl[4] = 8'h3E;
    check_regs("R3 split write");
  endtask

  task automatic t_power;
    logic [7:0] rx; logic ea, en;
    cs_on;
    send_byte(8'b0111_1000, rx, ea, en);
    mdl_pd = 1'b0;
    check_regs("R4 power up");
    send_byte({1'b0, 4'd1, 3'b000}, rx, ea, en);
    send_byte(8'hA5, rx, ea, en);
    cs_off;
    mdl[1] = 8'hA5;
    check_regs("R4 next byte is a command");
    cs_on; send_byte(8'b0111_1001, rx, ea, en); cs_off;
    mdl_pd = 1'b1;
    check_regs("R4 power down");
    cs_on; send_byte(8'b0111_1000, rx, ea, en); cs_off;
    mdl_pd = 1'b0;
  endtask

  task automatic t_read;
    logic [7:0] rx; logic ea, en;
    wr(4'd7, 8'hC3);
    cs_on;
    send_byte({1'b1, 4'd7, 3'b000}, rx, ea, en);
    chk(!en, "R6 read cmd byte", 128'(en), 0);
    send_byte(8'h5A, rx, ea, en);
    cs_off;
    chk(rx == 8'hC3, "R5 read data", 128'(rx), 128'(8'hC3));
    chk(ea, "R5 sdo_en during read", 128'(ea), 1);
    check_regs("R5 read data byte ignored");
    chk(!sdo_en, "R6 released after select rise", 128'(sdo_en), 0);
    cs_on;
    send_byte({1'b1, 4'd2, 3'b000}, rx, ea, en);
    send_byte(8'h00, rx, ea, en);
    cs_off;
    chk(rx == mdl[2], "R5 read second register", 128'(rx), 128'(mdl[2]));
  endtask

  task automatic t_abort;
    logic [7:0] rx; logic ea, en;
    cs_on; send_byte({1'b0, 4'd3, 3'b000}, rx, ea, en); cs_off;
    cs_on;
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_off;
    check_regs("R7 partial byte discarded");
    cs_on;
    send_byte({1'b0, 4'd5, 3'b000}, rx, ea, en);
    send_byte(8'h77, rx, ea, en);
    cs_off;
    mdl[5] = 8'h77;
    check_regs("R7 pending command cancelled");
  endtask

  task automatic t_bad_addr;
    wr(4'd12, 8'hEE);
    check_regs("R8 out of range write");
    wr(4'd6, 8'h19);
    check_regs("R8 normal write after");
  endtask

  task automatic t_cs_high_clocks;
    for (int i = 0; i < 16; i++) begin
      sdi = i[0]; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(HALF);
    check_regs("R9 clocks while deselected");
    wr(4'd8, 8'h42);
    check_regs("R9 state intact");
  endtask

  task automatic t_boundary;
    logic [7:0] rx; logic ea, en;
    logic [7:0] cmd;
    cmd = {1'b0, 4'd3, 3'b000};
    cs_on;
    for (int i = 7; i >= 0; i--) begin
      sdi = cmd[i];
      wait_clk(HALF);
      sclk = 1'b1;
      if (i == 0) cs_n = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_on; send_byte(8'h9D, rx, ea, en); cs_off;
    mdl[3] = 8'h9D;
    check_regs("R10 coincident select rise");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset;
    t_write_contig;
    t_write_split;
    t_power;
    t_read;
    t_abort;
    t_bad_addr;
    t_cs_high_clocks;
    t_boundary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule